// File: doc/BRIEF.md
# EDO DRAM Access Sequencer with Refresh

This block sits between a simple host port and a 4M-word by 4-bit EDO dynamic RAM. It turns one host read or write into one multiplexed strobe cycle. A 22-bit word address is split into an 11-bit row and an 11-bit column, and the two halves are driven one after the other on a shared address bus. The four active-low strobes are all registered. The 4-bit data bus is handled as a separate output path with its own drive enable and a separate input capture path. All cycle counts are derived from parameters given in nanoseconds and from the clock period. The defaults describe the 60 ns speed grade at an 8 ns clock.

The block also keeps the memory alive on its own. After reset it waits a power-up delay and then issues a burst of refresh cycles that strobe CAS before RAS. After that it schedules one such refresh at a fixed interval, set by default to 2,048 refreshes per 32 ms. A refresh that falls due while an access is running is latched. It is issued as soon as that access finishes, ahead of any new host request.

States: PWRUP (power-up wait), IDLE, ROW (row on bus), RASH (RAS low, row held), COL (column on bus), CAS (column strobe, data phase), RCAS (refresh: CAS low first), RRAS (refresh: RAS low), PRE (precharge). The transitions are as follows:
- PWRUP goes to RCAS when the delay expires.
- IDLE goes to RCAS while start-up refreshes remain or a refresh is pending.
- IDLE goes to ROW when a request is accepted.
- ROW goes to RASH, then COL, then CAS, then PRE.
- RCAS goes to RRAS, then PRE.
- PRE goes to IDLE.

Top module: `dram_edo_ctrl`

## Requirements
- R1: During reset and the power-up wait, dram_ras_n, dram_cas_n, dram_we_n and dram_oe_n are all 1, dram_dq_oe is 0 and req_ready is 0.
- R2: The first refresh starts no earlier than PWRUP_CYCLES cycles after reset is released. Exactly INIT_REFRESHES (8) refreshes are issued before req_ready first rises.
- R3: req_addr[21:11] is on dram_addr in the cycle before RAS falls, in the cycle RAS falls, and in the cycle after. req_addr[10:0] is on dram_addr in the cycle before CAS falls and in the cycle CAS falls.
- R4: In a write, WE falls together with CAS while RAS is low. dram_dq_oe is 1 and dram_dq_out equals req_wdata whenever WE is low, and OE stays 1.
- R5: WE and dram_dq_oe are never active while OE is low.
- R6: A read returns a single-cycle rd_valid pulse. rd_data is the dram_dq_in value sampled at the clock edge 8 cycles after the RAS falling edge, which is the latest of the limits from RAS, CAS and column address. rd_valid is seen in that same cycle.
- R7: Any two RAS falling edges are at least 13 cycles apart (104 ns). RAS stays high at least 5 cycles (40 ns) before every fall. Back-to-back requests run at exactly 13 cycles.
- R8: A refresh pulls CAS low while RAS is high. RAS falls on the next cycle, with WE high throughout. RAS then stays low for 8 cycles, which is well under 10 us.
- R9: With no host traffic, successive refreshes start exactly REF_WINDOW_US*1000/REF_ROWS/CLK_NS cycles apart (1953 by default).
- R10: A pending refresh is issued ahead of new host requests. Under continuous traffic, the spacing between refreshes stays within one access cycle plus two cycles of the nominal interval.
- R11: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only in IDLE, with RAS and CAS high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 11 bits |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 4 | Captured read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data returned by the memory |

## Verification
A state register that has gone wrong shows up on the strobes within one clock. Examples are a missed step in the access order, a skipped precharge, or a refresh entered from the wrong state. The symptom is then RAS falling with CAS already low outside a refresh, a RAS-to-RAS gap shorter than 13 cycles, or WE and OE low at the same time. A wrong phase count shifts the read capture edge by at least one cycle, and the bench's memory model presents inverted data before the valid time, so the fault appears as a wrong value on rd_data within that read. A fault in the refresh timer or the pending flag only shows up at the next interval, up to about 2,000 cycles later.

// File: rtl/dram_pkg.sv
package dram_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_ROW,
        ST_RASH,
        ST_COL,
        ST_CAS,
        ST_RCAS,
        ST_RRAS,
        ST_PRE
    } dram_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_phase_cnt.sv
module dram_phase_cnt #(
    parameter int W        = 8,
    parameter int INIT_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= W'(INIT_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q == TW'(INTERVAL - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == TW'(INTERVAL - 1));
endmodule

// File: rtl/dram_edo_ctrl.sv
module dram_edo_ctrl
    import dram_pkg::*;
#(
    parameter int CLK_NS         = 8,
    parameter int T_RAC_NS       = 60,
    parameter int T_CAC_NS       = 15,
    parameter int T_AA_NS        = 30,
    parameter int T_RC_NS        = 104,
    parameter int T_RP_NS        = 40,
    parameter int T_RAH_NS       = 10,
    parameter int REF_WINDOW_US  = 32000,
    parameter int REF_ROWS       = 2048,
    parameter int PWRUP_CYCLES   = 25000,
    parameter int INIT_REFRESHES = 8,
    parameter int AW             = 11,
    parameter int DW             = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [2*AW-1:0] req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            dram_ras_n,
    output logic            dram_cas_n,
    output logic            dram_we_n,
    output logic            dram_oe_n,
    output logic [AW-1:0]   dram_addr,
    output logic [DW-1:0]   dram_dq_out,
    output logic            dram_dq_oe,
    input  logic [DW-1:0]   dram_dq_in
);
    // Phase lengths in clock cycles
    localparam int RAH_CYC = imax(1, cdiv(T_RAH_NS, CLK_NS));
    localparam int CAP_CYC = imax(cdiv(T_RAC_NS, CLK_NS),
                             imax(RAH_CYC + 1 + cdiv(T_CAC_NS, CLK_NS),
                                  RAH_CYC + cdiv(T_AA_NS, CLK_NS)));
    localparam int CAS_CYC = imax(1, CAP_CYC - RAH_CYC - 1);
    localparam int RAS_CYC = RAH_CYC + 1 + CAS_CYC;
    localparam int RC_CYC  = cdiv(T_RC_NS, CLK_NS);
    localparam int RP_CYC  = cdiv(T_RP_NS, CLK_NS);
    // RAS is high for PRE plus IDLE plus ROW (or RCAS)
    localparam int PRE_CYC = imax(1, imax(RP_CYC - 2, RC_CYC - RAS_CYC - 2));
    localparam int REF_INT = (REF_WINDOW_US * 1000) / REF_ROWS / CLK_NS;
    localparam int MAX_PH  = imax(PWRUP_CYCLES, imax(RAS_CYC, PRE_CYC));
    localparam int CW      = $clog2(MAX_PH + 1);
    localparam int IW      = $clog2(INIT_REFRESHES + 1);

    dram_state_e state_q, state_d;

    logic            ph_load, ph_done;
    logic [CW-1:0]   ph_len;
    logic            ref_tick, ref_pend_q;
    logic [IW-1:0]   init_left_q;
    logic            accept, enter_ref;
    logic [2*AW-1:0] acc_addr_q;
    logic            acc_wr_q;
    logic [DW-1:0]   acc_wdata_q;

    assign req_ready = (state_q == ST_IDLE) && (init_left_q == '0) && !ref_pend_q;
    assign accept    = req_valid && req_ready;
    assign enter_ref = (state_d == ST_RCAS) && (state_q != ST_RCAS);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP: if (ph_done) state_d = ST_RCAS;
            ST_IDLE: begin
                if (init_left_q != '0 || ref_pend_q) state_d = ST_RCAS;
                else if (req_valid)                  state_d = ST_ROW;
            end
            ST_ROW:   state_d = ST_RASH;
            ST_RASH:  if (ph_done) state_d = ST_COL;
            ST_COL:   state_d = ST_CAS;
            ST_CAS:   if (ph_done) state_d = ST_PRE;
            ST_RCAS:  state_d = ST_RRAS;
            ST_RRAS:  if (ph_done) state_d = ST_PRE;
            ST_PRE:   if (ph_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase length for the state about to be entered
    always_comb begin
        unique case (state_d)
            ST_RASH: ph_len = CW'(RAH_CYC - 1);
            ST_CAS:  ph_len = CW'(CAS_CYC - 1);
            ST_RRAS: ph_len = CW'(RAS_CYC - 1);
            ST_PRE:  ph_len = CW'(PRE_CYC - 1);
            default: ph_len = '0;
        endcase
    end
    assign ph_load = (state_d != state_q);

    dram_phase_cnt #(.W(CW), .INIT_VAL(PWRUP_CYCLES - 1)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_len),
        .expired  (ph_done)
    );

    dram_refresh_timer #(.INTERVAL(REF_INT)) u_reftmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (init_left_q == '0),
        .tick  (ref_tick)
    );

    // State register and bookkeeping of refresh requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_PWRUP;
            init_left_q <= IW'(INIT_REFRESHES);
            ref_pend_q  <= 1'b0;
            acc_addr_q  <= '0;
            acc_wr_q    <= 1'b0;
            acc_wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (enter_ref && init_left_q != '0)
                init_left_q <= init_left_q - 1'b1;
            if (ref_tick)
                ref_pend_q <= 1'b1;
            else if (enter_ref && init_left_q == '0)
                ref_pend_q <= 1'b0;
            if (accept) begin
                acc_addr_q  <= req_addr;
                acc_wr_q    <= req_write;
                acc_wdata_q <= req_wdata;
            end
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_addr   <= '0;
            dram_dq_out <= '0;
            dram_dq_oe  <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
        end else begin
            dram_ras_n <= !(state_d inside {ST_RASH, ST_COL, ST_CAS, ST_RRAS});
            dram_cas_n <= !(state_d inside {ST_CAS, ST_RCAS, ST_RRAS});
            dram_we_n  <= !(state_d == ST_CAS && acc_wr_q);
            dram_oe_n  <= !(state_d == ST_CAS && !acc_wr_q);
            dram_dq_oe <= (state_d inside {ST_COL, ST_CAS}) && acc_wr_q;
            dram_dq_out <= acc_wdata_q;
            unique case (state_d)
                ST_ROW:         dram_addr <= req_addr[2*AW-1:AW];
                ST_RASH:        dram_addr <= acc_addr_q[2*AW-1:AW];
                ST_COL, ST_CAS: dram_addr <= acc_addr_q[AW-1:0];
                default:        dram_addr <= dram_addr;
            endcase
            rd_valid <= 1'b0;
            if (state_q == ST_CAS && ph_done && !acc_wr_q) begin
                rd_valid <= 1'b1;
                rd_data  <= dram_dq_in;
            end
        end
    end
endmodule

// File: rtl/dram_edo_ctrl_chk.sv
module dram_edo_ctrl_chk #(
    parameter int MIN_HIGH = 5,
    parameter int AW       = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rd_valid,
    input logic          dram_ras_n,
    input logic          dram_cas_n,
    input logic          dram_we_n,
    input logic          dram_oe_n,
    input logic          dram_dq_oe,
    input logic [AW-1:0] dram_addr
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= 16'hFFFF;
        else if (!dram_ras_n)
            hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF)
            hi_cnt <= hi_cnt + 1'b1;
    end

    a_r5_we_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (dram_we_n && !dram_dq_oe));

    a_r4_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (!dram_cas_n && !dram_ras_n && dram_dq_oe && dram_oe_n));

    a_r8_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_ras_n) |=> (!dram_ras_n && !dram_cas_n && dram_we_n));

    a_r3_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_cas_n) |-> $stable(dram_addr));

    a_r3_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_cas_n) |=> $stable(dram_addr));

    a_r3_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_addr));

    a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_cnt >= 16'(MIN_HIGH)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r11_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_n && dram_cas_n));
endmodule

bind dram_edo_ctrl dram_edo_ctrl_chk #(.MIN_HIGH(RP_CYC), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_oe_n  (dram_oe_n),
    .dram_dq_oe (dram_dq_oe),
    .dram_addr  (dram_addr)
);

// File: tb/dram_edo_ctrl_test.sv
`timescale 1ns/1ps
module dram_edo_ctrl_test;
    localparam int PWRUP   = 100;
    localparam int NINIT   = 8;
    localparam int CAP     = 8;
    localparam int RC      = 13;
    localparam int RP      = 5;
    localparam int REF_INT = 32000 * 1000 / 2048 / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [10:0] dram_addr;
    logic [3:0]  dram_dq_out;
    logic [3:0]  dram_dq_in = '0;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    dram_edo_ctrl #(.PWRUP_CYCLES(PWRUP), .INIT_REFRESHES(NINIT)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    // Port monitor and memory model, sampled on the falling edge
    logic [3:0]  mem [logic [21:0]];
    int          cyc = 0, rel_cyc = 0, ras_k = 0;
    int          last_fall = 0, last_rise = 0, last_fall_gap = 0;
    int          ref_count = 0, first_ref_cyc = 0, last_ref_start = 0, last_ref_gap = 0;
    int          ref_low_len = 0, acc_done = 0, rd_cnt = 0, rd_lat = 0;
    int          viol_r3 = 0, viol_r5 = 0, viol_r7 = 0, viol_r8 = 0;
    bit          have_fall = 0, in_ref = 0, col_known = 0, exp_ras_next = 0, wr_ok = 0;
    logic        prev_ras = 1'b1, prev_cas = 1'b1;
    logic [10:0] prev_addr = '0, row_lat = '0, col_lat = '0;
    logic [3:0]  wr_dq = '0, rd_val = '0;

    always @(negedge clk) begin
        cyc++;
        if (exp_ras_next) begin
            if (dram_ras_n || dram_cas_n) viol_r8++;
            exp_ras_next = 0;
        end
        if (prev_ras && !dram_ras_n) begin
            in_ref = !prev_cas;
            if (have_fall) begin
                last_fall_gap = cyc - last_fall;
                if (last_fall_gap < RC) viol_r7++;
            end
            if (cyc - last_rise < RP) viol_r7++;
            have_fall = 1; last_fall = cyc; ras_k = 0; col_known = 0;
            if (!in_ref) begin
                row_lat = dram_addr;
                if (dram_addr != prev_addr) viol_r3++;
            end
        end else if (!dram_ras_n) begin
            ras_k++;
        end
        if (!dram_ras_n && !in_ref && ras_k == 1 && dram_addr != row_lat) viol_r3++;
        if (!prev_ras && dram_ras_n) begin
            last_rise = cyc;
            if (in_ref) ref_low_len = cyc - last_fall;
            else acc_done++;
        end
        if (prev_cas && !dram_cas_n) begin
            if (dram_ras_n) begin
                ref_count++;
                if (ref_count == 1) first_ref_cyc = cyc;
                else last_ref_gap = cyc - last_ref_start;
                last_ref_start = cyc;
                exp_ras_next = 1;
            end else begin
                col_lat = dram_addr; col_known = 1;
                if (dram_addr != prev_addr) viol_r3++;
                if (!dram_we_n) begin
                    wr_dq = dram_dq_out;
                    wr_ok = dram_dq_oe && dram_oe_n;
                    mem[{row_lat, col_lat}] = dram_dq_out;
                end
            end
        end
        if (!dram_ras_n && in_ref && !dram_we_n) viol_r8++;
        if (!dram_oe_n && (!dram_we_n || dram_dq_oe)) viol_r5++;
        if (!dram_ras_n && !in_ref && col_known && mem.exists({row_lat, col_lat}))
            dram_dq_in = (ras_k >= CAP - 1) ? mem[{row_lat, col_lat}] : ~mem[{row_lat, col_lat}];
        else
            dram_dq_in = 4'h0;
        if (rd_valid) begin
            rd_cnt++; rd_val = rd_data; rd_lat = cyc - last_fall;
        end
        prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_addr = dram_addr;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [21:0] a, input logic w, input logic [3:0] d);
        @(negedge clk);
        req_addr = a; req_write = w; req_wdata = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state;
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        rst_n = 1'b1; rel_cyc = cyc;
        repeat (PWRUP - 10) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in power-up",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        check(!req_ready && !dram_dq_oe, "R1 ready/dq_oe in power-up", {req_ready, dram_dq_oe}, 0);
    endtask

    task automatic t_init;
        while (!req_ready) @(negedge clk);
        check(ref_count == NINIT, "R2 start-up refresh count", ref_count, NINIT);
        check(first_ref_cyc - rel_cyc >= PWRUP, "R2 power-up delay", first_ref_cyc - rel_cyc, PWRUP);
        check(ref_low_len == CAP && viol_r8 == 0, "R8 refresh RAS width/order", ref_low_len, CAP);
    endtask

    task automatic t_write(input logic [21:0] a, input logic [3:0] d);
        int n;
        n = acc_done;
        issue(a, 1'b1, d);
        while (acc_done == n) @(negedge clk);
        check(wr_dq == d && wr_ok, "R4 write data/strobes", {wr_ok, wr_dq}, {1'b1, d});
        check(row_lat == a[21:11], "R3 write row", row_lat, a[21:11]);
        check(col_lat == a[10:0], "R3 write column", col_lat, a[10:0]);
    endtask

    task automatic t_read(input logic [21:0] a, input logic [3:0] exp);
        int n;
        n = rd_cnt;
        issue(a, 1'b0, 4'h0);
        while (rd_cnt == n) @(negedge clk);
        check(rd_val == exp, "R6 read data", rd_val, exp);
        check(rd_lat == CAP, "R6 capture latency", rd_lat, CAP);
        check(row_lat == a[21:11] && col_lat == a[10:0], "R3 read address split",
              {row_lat, col_lat}, a);
    endtask

    task automatic t_back_to_back;
        int r0;
        r0 = ref_count;
        issue(22'h155AAA, 1'b1, 4'h3);
        issue(22'h2AA555, 1'b1, 4'hC);
        repeat (RC + 2) @(negedge clk);
        if (ref_count == r0)
            check(last_fall_gap == RC, "R7 back-to-back RAS spacing", last_fall_gap, RC);
        check(viol_r7 == 0, "R7 RAS cycle/precharge violations", viol_r7, 0);
    endtask

    task automatic t_idle_refresh;
        int r0;
        r0 = ref_count;
        while (ref_count < r0 + 2) @(negedge clk);
        check(last_ref_gap == REF_INT, "R9 idle refresh interval", last_ref_gap, REF_INT);
    endtask

    task automatic t_refresh_under_load;
        int r0, lo, hi;
        bit ok = 1;
        r0 = ref_count; lo = REF_INT; hi = REF_INT;
        while (ref_count < r0 + 2) begin
            t_read(22'h155AAA, 4'h3);
            if (ref_count > r0 + 1 || (ref_count == r0 + 1 && r0 > 0)) begin
                if (last_ref_gap < lo) lo = last_ref_gap;
                if (last_ref_gap > hi) hi = last_ref_gap;
            end
        end
        ok = (lo >= REF_INT - RC - 2) && (hi <= REF_INT + RC + 2);
        check(ok, "R10 refresh spacing under load", hi, REF_INT);
        check(viol_r8 == 0 && ref_low_len == CAP, "R8 refresh under load", viol_r8, 0);
        t_read(22'h2AA555, 4'hC);
    endtask

    initial begin
        t_reset_state();
        t_init();
        t_back_to_back();
        t_write(22'h000001, 4'h9);
        t_write(22'h3FFFFE, 4'h6);
        t_write(22'h2AB3CD, 4'hF);
        t_read(22'h000001, 4'h9);
        t_read(22'h3FFFFE, 4'h6);
        t_read(22'h2AB3CD, 4'hF);
        t_read(22'h155AAA, 4'h3);
        check(viol_r5 == 0, "R5 WE/OE exclusion", viol_r5, 0);
        check(viol_r3 == 0, "R3 address setup/hold", viol_r3, 0);
        t_idle_refresh();
        t_refresh_under_load();
        check(viol_r7 == 0 && viol_r5 == 0, "R11 R7 R5 final sweep", viol_r7 + viol_r5, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule